// File: doc/BRIEF.md
# Keyboard Matrix Column Scanner

This block turns a 56-key matrix, arranged as 8 columns of 7 keys, into the 7-bit row pattern that software reads from a data port. Software first writes an 8-bit scan-control byte. The byte either names one column, so that the read returns only that column's keys, or asks for every column merged into one pattern. Every other byte value returns an empty pattern.

Key state arrives already debounced as a flat vector. Key number `col*7 + row` sits at bit position `col*7 + row`. The row pattern is captured into an output register on the clock edge where the read strobe is high. It holds its value until the next strobe. The stored scan byte can be read back at any time on a 32-bit word.

Top module: `kbd_matrix_scanner`

## Requirements
- R1: While reset is active, and after reset until the first scan write, the stored scan byte is 0x00. Until the first strobe, `row_data` reads 0x00.
- R2: A write strobe stores all 8 bits of `scan_wdata` into the scan byte at that clock edge. From the next cycle, `scan_rdata` shows that byte zero-extended to 32 bits.
- R3: When bit 3 of the scan byte is 1, bits 2:0 select column c, whatever bits 7:4 hold. A read then returns row bit i equal to key `c*7 + i`, for i from 0 to 6.
- R4: When the scan byte equals 0x00, a read returns row bit r set if any key k with k mod 7 equal to r is pressed.
- R5: When bit 3 of the scan byte is 0 and the byte is not 0x00, a read returns 0x00 whatever keys are pressed.
- R6: Bit 7 of `row_data` is always 0.
- R7: `row_data` changes only on a clock edge where `row_rd` is high. It then reflects the scan byte stored before that edge and the key state present at that edge. On every other edge it holds its value, even when keys or the scan byte change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| scan_wr | input | 1 | Write strobe for the scan byte |
| scan_wdata | input | 8 | Scan byte to store |
| scan_rdata | output | 32 | Stored scan byte, zero-extended |
| key_state | input | 56 | Debounced key state; bit col*7+row set means pressed |
| row_rd | input | 1 | Read strobe; captures the row pattern |
| row_data | output | 8 | Row pattern on bits 6:0; bit 7 is zero |

## Verification
A row pattern is due one rising edge after the strobe that requests it. A scan write shows on the readback one edge after its strobe. So when a write and a read share an edge, the read still uses the old byte. The bench drives inputs on the falling edge and updates its reference model on the rising edge. It compares both outputs with the model on the next falling edge. Each comparison is tagged by the mode the model decoded for that read, or by the hold rule when no read was strobed.

// File: rtl/kbd_scan_pkg.sv
package kbd_scan_pkg;

   typedef enum logic [1:0] {
      MODE_MERGE  = 2'd0,
      MODE_COLUMN = 2'd1,
      MODE_BLANK  = 2'd2
   } scan_mode_e;

   // Decode the stored scan byte into a mode: the column flag wins,
   // an all-zero byte merges, anything else reads empty.
   function automatic scan_mode_e classify_scan(input logic col_flag,
                                                input logic any_bit_set);
      scan_mode_e m;
      if (col_flag)
         m = MODE_COLUMN;
      else if (any_bit_set)
         m = MODE_BLANK;
      else
         m = MODE_MERGE;
      return m;
   endfunction

endpackage

// File: rtl/kbd_col_select.sv
module kbd_col_select #(
   parameter int NUM_COLS = 8,
   parameter int NUM_ROWS = 7,
   parameter int SEL_W    = $clog2(NUM_COLS)
) (
   input  logic [NUM_COLS*NUM_ROWS-1:0] keys,
   input  logic [SEL_W-1:0]             col,
   output logic [NUM_ROWS-1:0]          pattern
);

   logic [NUM_ROWS-1:0] slice [NUM_COLS];

   for (genvar c = 0; c < NUM_COLS; c++) begin : g_slice
      assign slice[c] = keys[c*NUM_ROWS +: NUM_ROWS];
   end

   assign pattern = slice[col];

endmodule

// File: rtl/kbd_col_merge.sv
module kbd_col_merge #(
   parameter int NUM_COLS = 8,
   parameter int NUM_ROWS = 7
) (
   input  logic [NUM_COLS*NUM_ROWS-1:0] keys,
   output logic [NUM_ROWS-1:0]          pattern
);

   always_comb begin
      pattern = '0;
      for (int c = 0; c < NUM_COLS; c++) begin
         pattern = pattern | keys[c*NUM_ROWS +: NUM_ROWS];
      end
   end

endmodule

// File: rtl/kbd_matrix_scanner.sv
module kbd_matrix_scanner
   import kbd_scan_pkg::*;
#(
   parameter int NUM_COLS = 8,
   parameter int NUM_ROWS = 7,
   parameter int WR_W     = 8,
   parameter int DATA_W   = 8,
   parameter int RDBK_W   = 32,
   parameter bit REG_OUT  = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          scan_wr,
   input  logic [WR_W-1:0]               scan_wdata,
   output logic [RDBK_W-1:0]             scan_rdata,
   input  logic [NUM_COLS*NUM_ROWS-1:0]  key_state,
   input  logic                          row_rd,
   output logic [DATA_W-1:0]             row_data
);

   localparam int SEL_W  = $clog2(NUM_COLS);
   localparam int KEYS   = NUM_COLS * NUM_ROWS;
   localparam int PAD_W  = DATA_W - NUM_ROWS;

   // elaboration-time parameter checks
   if (NUM_COLS < 2 || (NUM_COLS & (NUM_COLS - 1)) != 0) begin : g_bad_cols
      $error("NUM_COLS must be a power of two of at least 2");
   end
   if (WR_W < SEL_W + 1) begin : g_bad_wr
      $error("WR_W too narrow for column select and column flag");
   end
   if (DATA_W <= NUM_ROWS) begin : g_bad_data
      $error("DATA_W must exceed NUM_ROWS");
   end
   if (RDBK_W < WR_W) begin : g_bad_rdbk
      $error("RDBK_W must hold the whole scan byte");
   end

   logic [WR_W-1:0]     scan_q;
   scan_mode_e          mode;
   logic [NUM_ROWS-1:0] col_pat;
   logic [NUM_ROWS-1:0] merge_pat;
   logic [NUM_ROWS-1:0] row_pat;
   logic [DATA_W-1:0]   row_next;

   // scan control register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         scan_q <= '0;
      else if (scan_wr)
         scan_q <= scan_wdata;
   end

   assign scan_rdata = RDBK_W'(scan_q);
   assign mode       = classify_scan(scan_q[SEL_W], |scan_q);

   kbd_col_select #(
      .NUM_COLS (NUM_COLS),
      .NUM_ROWS (NUM_ROWS),
      .SEL_W    (SEL_W)
   ) u_col_select (
      .keys    (key_state),
      .col     (scan_q[SEL_W-1:0]),
      .pattern (col_pat)
   );

   kbd_col_merge #(
      .NUM_COLS (NUM_COLS),
      .NUM_ROWS (NUM_ROWS)
   ) u_col_merge (
      .keys    (key_state),
      .pattern (merge_pat)
   );

   always_comb begin
      unique case (mode)
         MODE_COLUMN: row_pat = col_pat;
         MODE_MERGE:  row_pat = merge_pat;
         default:     row_pat = '0;
      endcase
   end

   assign row_next = {{PAD_W{1'b0}}, row_pat};

   if (REG_OUT) begin : g_reg_out
      logic [DATA_W-1:0] row_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            row_q <= '0;
         else if (row_rd)
            row_q <= row_next;
      end

      assign row_data = row_q;

      // R7
      hold_without_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !row_rd |=> $stable(row_data))
         else $error("row_data moved without a read strobe");

      // R5
      blank_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (row_rd && !scan_q[SEL_W] && (scan_q != '0)) |=> (row_data == '0))
         else $error("non-zero code without column flag returned keys");
   end else begin : g_comb_out
      assign row_data = row_next;
   end

   // R6
   pad_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      row_data[DATA_W-1:NUM_ROWS] == '0)
      else $error("row_data pad bits not zero");

   // R2
   scan_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scan_wr |=> (scan_rdata == RDBK_W'($past(scan_wdata))))
      else $error("scan readback does not match written byte");

endmodule

// File: tb/kbd_matrix_scanner_bench.sv
`timescale 1ns/1ps
module kbd_matrix_scanner_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scan_wr = 1'b0;
   logic [7:0]  scan_wdata = '0;
   logic [31:0] scan_rdata;
   logic [55:0] key_state = '0;
   logic        row_rd = 1'b0;
   logic [7:0]  row_data;

   int errors = 0;
   int checks = 0;
   bit run_on = 1'b0;
   bit done = 1'b0;

   // reference model state
   int    m_scan = 0;
   int    m_row = 0;
   string m_tag = "R1";

   always #4 clk = ~clk;

   kbd_matrix_scanner u_kbd_matrix_scanner (
      .clk        (clk),
      .rst_n      (rst_n),
      .scan_wr    (scan_wr),
      .scan_wdata (scan_wdata),
      .scan_rdata (scan_rdata),
      .key_state  (key_state),
      .row_rd     (row_rd),
      .row_data   (row_data)
   );

   function automatic int ref_pattern(int scan, logic [55:0] keys);
      int res = 0;
      if ((scan & 8) != 0) begin
         int c = scan % 8;
         for (int r = 0; r < 7; r++)
            if (keys[c*7 + r]) res = res | (1 << r);
      end else if (scan == 0) begin
         for (int k = 0; k < 56; k++)
            if (keys[k]) res = res | (1 << (k % 7));
      end
      return res;
   endfunction

   function automatic string mode_tag(int scan);
      if ((scan & 8) != 0) return "R3";
      if (scan == 0) return "R4";
      return "R5";
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_scan <= 0;
         m_row  <= 0;
         m_tag  <= "R1";
      end else begin
         if (row_rd) begin
            m_row <= ref_pattern(m_scan, key_state);
            m_tag <= mode_tag(m_scan);
         end else begin
            m_tag <= (m_tag == "R1") ? "R1" : "R7";
         end
         if (scan_wr) m_scan <= int'(scan_wdata);
      end
   end

   task automatic check(string tag, int actual, int expected);
      checks++;
      if (actual != expected) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, actual, expected, $time);
      end
   endtask

   always @(negedge clk) begin
      if (run_on && !done) begin
         check(m_tag, int'(row_data[6:0]), m_row);
         check("R6", int'(row_data[7]), 0);
         check((m_tag == "R1") ? "R1" : "R2", int'(scan_rdata), m_scan);
      end
   end

   task automatic tick(input logic wr, input logic [7:0] wd,
                       input logic rd, input logic [55:0] keys);
      @(negedge clk);
      scan_wr    = wr;
      scan_wdata = wd;
      row_rd     = rd;
      key_state  = keys;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      run_on = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset values observed over idle cycles
      tick(0, 8'h00, 0, 56'h0);
      tick(0, 8'h00, 0, '1);
      // R4: merged mode straight out of reset
      tick(0, 8'h00, 1, 56'h1);
      tick(0, 8'h00, 1, '1);
      // R3: walk every column
      for (int c = 0; c < 8; c++) begin
         logic [55:0] kv = {$urandom, $urandom};
         tick(1, 8'(8 + c), 0, kv);
         tick(0, 8'h00, 1, kv);
      end
      // R3: upper bits set with column flag, column 1
      tick(1, 8'hF9, 0, 56'h0);
      tick(0, 8'h00, 1, 56'h3F80);
      // R4: every single key merged
      tick(1, 8'h00, 0, 56'h0);
      for (int k = 0; k < 56; k++)
         tick(0, 8'h00, 1, 56'h1 << k);
      // R5: blank codes with all keys pressed
      for (int s = 1; s < 8; s++) begin
         tick(1, 8'(s), 0, '1);
         tick(0, 8'h00, 1, '1);
      end
      tick(1, 8'h10, 1, '1);
      tick(0, 8'h00, 1, '1);
      tick(1, 8'hF0, 0, '1);
      tick(0, 8'h00, 1, '1);
      // R7: hold while keys and scan change without a strobe
      tick(1, 8'h0C, 1, '1);
      tick(1, 8'h00, 0, 56'h0);
      tick(0, 8'h00, 0, 56'h5555);
      tick(0, 8'h00, 0, '1);
      // R7: write and read on one edge uses the old byte
      tick(1, 8'h0A, 1, 56'h7F << 14);
      tick(0, 8'h00, 1, 56'h7F << 14);
      // mixed random traffic
      for (int i = 0; i < 400; i++) begin
         logic [7:0] wd = 8'($urandom);
         if ($urandom % 3 == 0) wd = 8'h00;
         tick(1'($urandom), wd, 1'($urandom), {$urandom, $urandom});
      end
      tick(0, 8'h00, 0, 56'h0);
      @(negedge clk);
      @(posedge clk);
      finish_run();
   end

endmodule